// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block sits between one processor and a shared, atomic system bus in a small shared-memory multiprocessor. It holds a direct-mapped array of one-word lines, each either Valid or Invalid, where Invalid stands both for a line that was never loaded and for one that lost its copy. Processor reads that hit are answered from the array without touching the bus. Read misses go to memory and load the line. Every processor write is carried to memory on the bus, and a write that misses leaves the array alone.

Coherence comes from watching the bus. Each transaction another agent places on the shared bus is presented on the snoop inputs. A foreign write whose address matches a Valid line turns that line Invalid. The controller's own transactions, identified by the source field, never touch its own lines. A bus access runs through three phases: arbitration (request held until granted), one command/address cycle, and a data phase that ends with the memory acknowledge. Only one processor request is in flight at a time.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid and `bus_req`, `bus_cmd_valid` and `cpu_ready` are low.
- R2: A read whose line is Invalid or holds another tag runs one bus read (`bus_cmd_write` = 0) at the request address, returns the acknowledged `bus_rdata`, and leaves the line Valid so the next read of that address hits.
- R3: A read that hits a Valid line returns the stored word and causes no bus transaction.
- R4: Every write, hit or miss, runs exactly one bus write (`bus_cmd_write` = 1) carrying the request address and data.
- R5: A write miss does not allocate: a following read of that address misses and uses the bus.
- R6: A write hit updates the stored word; a following read hits and returns the written data.
- R7: A snooped write from another source (`snp_src` differs from `AGENT_ID`) to the exact address of a Valid line makes it Invalid, so the next read misses and returns the newer memory word.
- R8: A snooped write to the same index with a different tag, and any snooped read, leave the line Valid.
- R9: Snooped transactions whose `snp_src` equals `AGENT_ID` never change line state.
- R10: If a foreign snooped write to the address being filled arrives in the same cycle as the fill acknowledge, the processor receives the fill data but the line stays Invalid; the next read misses and returns the newer word.
- R11: `bus_req` stays high from the start of arbitration until granted; `bus_cmd_valid` is high for exactly one cycle, and only while `bus_gnt` is high; the address and command are zero outside the granted phases.
- R12: Each accepted request produces exactly one single-cycle `cpu_ready` pulse, one cycle after the bus acknowledge for a bus operation, and no new request is taken before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address; low log2(LINES) bits select the line |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_ready` |
| bus_req | output | 1 | Arbitration request |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_cmd_valid | output | 1 | Command/address phase strobe |
| bus_cmd_write | output | 1 | Command is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Memory ends the data phase |
| bus_rdata | input | DATA_W | Memory read data, valid with `bus_ack` |
| snp_valid | input | 1 | A transaction is visible on the shared bus |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_src | input | SRC_W | Agent number of the snooped transaction's master |
| snp_addr | input | ADDR_W | Snooped address |

## Verification
The two functions that can meet in one cycle are the local fill of a line at the bus acknowledge and the invalidation of that same line by a foreign snooped write. The memory model provokes the collision by presenting a foreign write to the address under fill in the very cycle it raises the acknowledge for that read, updating memory after supplying the old word. The outcome is judged at the ports: the processor must receive the old word, and the following read of the address must go to the bus and return the newer word, followed by a hit.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through snooping cache controller.
// Assumes: nothing beyond a single clock domain.
package wtc_pkg;

    // Controller sequencing: idle, arbitration, command, data, response.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARB  = 3'd1,
        ST_CMD  = 3'd2,
        ST_DATA = 3'd3,
        ST_RESP = 3'd4
    } wtc_state_e;

endpackage

// File: rtl/wtc_line_store.sv
// Direct-mapped array of one-word lines with a Valid bit each.
// One combinational lookup port, one write port (fill or write-hit update)
// and one invalidate port. An invalidate naming the exact address being
// written in the same cycle discards the write and leaves the line Invalid.
// Assumes LINES is a power of two, at least 2, and below 2**ADDR_W.
module wtc_line_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [ADDR_W-1:0] inv_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [IDX_W-1:0] lk_idx, wr_idx, inv_idx;
    logic [TAG_W-1:0] lk_tag, inv_tag;
    logic             fill_killed;

    assign lk_idx  = lk_addr[IDX_W-1:0];
    assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
    assign wr_idx  = wr_addr[IDX_W-1:0];
    assign inv_idx = inv_addr[IDX_W-1:0];
    assign inv_tag = inv_addr[ADDR_W-1:IDX_W];

    // Same-cycle collision of a write and a foreign invalidate on one address.
    assign fill_killed = wr_en && inv_en && (inv_addr == wr_addr);

    // Lookup: hit when the indexed line is Valid and its tag matches.
    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_data = data_q[lk_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic wr_sel, inv_match;
        assign wr_sel    = wr_en && (wr_idx == IDX_W'(g));
        assign inv_match = inv_en && (inv_idx == IDX_W'(g)) && valid_q[g] &&
                           (tag_q[g] == inv_tag);

        // Per-line state update: collision kills, writes load, matches invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_sel && fill_killed) begin
                valid_q[g] <= 1'b0;
            end else if (wr_sel) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= wr_addr[ADDR_W-1:IDX_W];
                data_q[g]  <= wr_data;
            end else if (inv_match) begin
                valid_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wtc_snoop_filter.sv
// Turns the observed shared-bus traffic into an invalidate request.
// Only foreign writes qualify; reads and this agent's own transactions
// are dropped. Tag comparison against the stored line is done in the store.
// Assumes one transaction per cycle at most on the snoop inputs.
module wtc_snoop_filter #(
    parameter int ADDR_W   = 16,
    parameter int SRC_W    = 2,
    parameter int AGENT_ID = 1
) (
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [SRC_W-1:0]  snp_src,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              inv_en,
    output logic [ADDR_W-1:0] inv_addr
);
    localparam logic [SRC_W-1:0] SELF = SRC_W'(AGENT_ID);

    // Qualify: a write, visible on the bus, mastered by someone else.
    always_comb begin
        inv_en   = snp_valid && snp_write && (snp_src != SELF);
        inv_addr = snp_addr;
    end
endmodule

// File: rtl/wtc_bus_fsm.sv
// Request sequencer: takes one processor request at a time, answers read
// hits locally, and runs arbitration, command and data phases for misses
// and for every write. Issues fills and write-hit updates to the store.
// Assumes the arbiter keeps the grant while the request stays high and
// that memory raises bus_ack once per transaction, in the data phase.
module wtc_bus_fsm
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    wtc_state_e        state_q, state_d;
    logic              op_write_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept, on_bus, finish;

    assign accept = (state_q == ST_IDLE) && cpu_req_valid;
    assign on_bus = (state_q == ST_CMD) || (state_q == ST_DATA);
    assign finish = (state_q == ST_DATA) && bus_ack;

    // Lookup follows the new request while idle, the held one otherwise.
    assign lk_addr = (state_q == ST_IDLE) ? cpu_req_addr : op_addr_q;

    // Next-state selection for the request sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (!cpu_req_write && lk_hit) ? ST_RESP : ST_ARB;
            ST_ARB:  if (bus_gnt) state_d = ST_CMD;
            ST_CMD:  state_d = ST_DATA;
            ST_DATA: if (bus_ack) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the accepted request; it is held until the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write_q <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
        end else if (accept) begin
            op_write_q <= cpu_req_write;
            op_addr_q  <= cpu_req_addr;
            op_wdata_q <= cpu_req_wdata;
        end
    end

    // Read result: stored word on a hit, memory word on a bus read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept && !cpu_req_write && lk_hit) begin
            rdata_q <= lk_data;
        end else if (finish && !op_write_q) begin
            rdata_q <= bus_rdata;
        end
    end

    // Store updates: fill on every read ack, update only if the line still hits.
    assign wr_en   = finish && (!op_write_q || lk_hit);
    assign wr_addr = op_addr_q;
    assign wr_data = op_write_q ? op_wdata_q : bus_rdata;

    // Bus drive: request through all bus phases, address only when granted.
    assign bus_req       = (state_q == ST_ARB) || on_bus;
    assign bus_cmd_valid = (state_q == ST_CMD);
    assign bus_cmd_write = on_bus && op_write_q;
    assign bus_addr      = on_bus ? op_addr_q : '0;
    assign bus_wdata     = (on_bus && op_write_q) ? op_wdata_q : '0;

    // Processor response.
    assign cpu_ready = (state_q == ST_RESP);
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/wt_snoop_ctrl.sv
// Write-through, no-write-allocate cache controller with snoop invalidation
// for an atomic shared bus. Instantiates the sequencer, the line store and
// the snoop filter. Assumes the snoop inputs show every bus transaction,
// including this agent's own, tagged with the master's agent number.
module wt_snoop_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int LINES    = 8,
    parameter int SRC_W    = 2,
    parameter int AGENT_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [SRC_W-1:0]  snp_src,
    input  logic [ADDR_W-1:0] snp_addr
);
    logic [ADDR_W-1:0] lk_addr, wr_addr, inv_addr;
    logic              lk_hit, wr_en, inv_en;
    logic [DATA_W-1:0] lk_data, wr_data;

    wtc_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_ready     (cpu_ready),
        .cpu_rdata     (cpu_rdata),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd_write (bus_cmd_write),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata),
        .lk_addr       (lk_addr),
        .lk_hit        (lk_hit),
        .lk_data       (lk_data),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data)
    );

    wtc_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (lk_addr),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .inv_en   (inv_en),
        .inv_addr (inv_addr)
    );

    wtc_snoop_filter #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .AGENT_ID(AGENT_ID)) u_snoop (
        .snp_valid (snp_valid),
        .snp_write (snp_write),
        .snp_src   (snp_src),
        .snp_addr  (snp_addr),
        .inv_en    (inv_en),
        .inv_addr  (inv_addr)
    );
endmodule

// File: rtl/wtc_checker.sv
// Protocol checks on the controller's bus and processor handshakes.
// Bound to every instance of the top module.
module wtc_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_cmd_valid,
    input logic bus_ack,
    input logic cpu_ready
);
    // R11: the command phase only happens under grant.
    a_r11_cmd_granted: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> bus_gnt);

    // R11: an ungranted request is not withdrawn.
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R11: the command strobe lasts one cycle.
    a_r11_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |=> !bus_cmd_valid);

    // R12: completion is a single-cycle pulse.
    a_r12_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R2 / R12: a data-phase acknowledge completes the request next cycle.
    a_r2_ack_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_req) |=> cpu_ready);
endmodule

bind wt_snoop_ctrl wtc_checker u_chk (.*);

// File: tb/tb_wt_snoop_ctrl.sv
// Scoreboard bench: the driver task queues expected results per request;
// a monitor branch pops them on each completion and compares data and the
// bus traffic seen since the previous completion.
module tb_wt_snoop_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = 2;
    localparam int ME = 1;
    localparam int OTHER = 2;
    localparam int GDLY = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_ready, bus_req, bus_cmd_valid, bus_cmd_write;
    logic [DW-1:0] cpu_rdata, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt, bus_ack;
    logic [DW-1:0] bus_rdata;
    logic          snp_valid, snp_write;
    logic [SW-1:0] snp_src;
    logic [AW-1:0] snp_addr;

    wt_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(8), .SRC_W(SW), .AGENT_ID(ME)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_write(bus_cmd_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_src(snp_src), .snp_addr(snp_addr)
    );

    function automatic logic [DW-1:0] init_word(int i);
        return 32'hC0DE_0000 | DW'(i);
    endfunction

    // ---------------- environment: arbiter, memory, foreign agent ----------------
    logic [DW-1:0] mem [256];
    logic          pend;
    int            cnt, gwait;
    logic          c_wr;
    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_data;
    logic          fsnp_v, fsnp_w;
    logic [AW-1:0] fsnp_a;
    int            inj_done;
    // written only by the stimulus initial block
    int            inj_seq = 0;
    logic          inj_race = 1'b0, inj_wr = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [DW-1:0] inj_data = '0;

    assign snp_valid = fsnp_v | bus_cmd_valid;
    assign snp_write = fsnp_v ? fsnp_w : bus_cmd_write;
    assign snp_src   = fsnp_v ? SW'(OTHER) : SW'(ME);
    assign snp_addr  = fsnp_v ? fsnp_a : bus_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0; gwait <= GDLY; bus_ack <= 1'b0; bus_rdata <= '0;
            pend <= 1'b0; cnt <= 0; c_wr <= 1'b0; c_addr <= '0; c_data <= '0;
            fsnp_v <= 1'b0; fsnp_w <= 1'b0; fsnp_a <= '0; inj_done <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
        end else begin
            bus_ack <= 1'b0;
            fsnp_v  <= 1'b0;
            if (!bus_req) begin
                bus_gnt <= 1'b0; gwait <= GDLY;
            end else if (gwait != 0) begin
                gwait <= gwait - 1;
            end else begin
                bus_gnt <= 1'b1;
            end
            if (bus_cmd_valid) begin
                pend <= 1'b1; cnt <= 2;
                c_wr <= bus_cmd_write; c_addr <= bus_addr; c_data <= bus_wdata;
            end else if (pend) begin
                if (cnt != 0) begin
                    cnt <= cnt - 1;
                end else begin
                    pend <= 1'b0; bus_ack <= 1'b1; bus_rdata <= mem[c_addr[7:0]];
                    if (c_wr) begin
                        mem[c_addr[7:0]] <= c_data;
                    end else if (inj_race && inj_seq != inj_done) begin
                        fsnp_v <= 1'b1; fsnp_w <= 1'b1; fsnp_a <= inj_addr;
                        mem[inj_addr[7:0]] <= inj_data;
                        inj_done <= inj_seq;
                    end
                end
            end else if (!inj_race && inj_seq != inj_done && !bus_req) begin
                fsnp_v <= 1'b1; fsnp_w <= inj_wr; fsnp_a <= inj_addr;
                if (inj_wr) mem[inj_addr[7:0]] <= inj_data;
                inj_done <= inj_seq;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            is_wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] exp_data;
        int            exp_bus;
        string         tag;
    } item_t;

    item_t         sbq[$];
    logic [DW-1:0] exp_mem [256];
    int total = 0, bad = 0, n_ops = 0, n_ready = 0;
    int viol_gnt = 0, viol_req = 0, viol_ready = 0;
    bit wd_fired = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: queue the expectation, then run the request handshake.
    task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int exp_bus, input string tag);
        item_t it;
        it.is_wr = wr; it.addr = a; it.wdata = d;
        it.exp_data = exp_mem[a[7:0]]; it.exp_bus = exp_bus; it.tag = tag;
        if (wr) exp_mem[a[7:0]] = d;
        sbq.push_back(it);
        n_ops++;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
        do @(negedge clk); while (!cpu_ready);
        cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
    endtask

    // Foreign agent transaction presented on the snoop lines while idle.
    task automatic foreign(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        inj_race = 1'b0; inj_wr = wr; inj_addr = a; inj_data = d;
        if (wr) exp_mem[a[7:0]] = d;
        inj_seq++;
        while (inj_done != inj_seq) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: bus observation and completion comparison.
    task automatic monitor();
        int            bus_cnt = 0;
        logic          cap_w = 1'b0, p_req = 1'b0, p_gnt = 1'b0, p_rdy = 1'b0;
        logic [AW-1:0] cap_a = '0;
        logic [DW-1:0] cap_d = '0;
        item_t         it;
        forever begin
            @(negedge clk);
            if (bus_cmd_valid) begin
                bus_cnt++; cap_w = bus_cmd_write; cap_a = bus_addr; cap_d = bus_wdata;
                if (!bus_gnt) viol_gnt++;
            end
            if (p_req && !p_gnt && !bus_req) viol_req++;
            if (cpu_ready) begin
                n_ready++;
                if (p_rdy) viol_ready++;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R12 unexpected completion", 1, 0);
                end else begin
                    it = sbq.pop_front();
                    chk(bus_cnt == it.exp_bus, {it.tag, " bus transactions"},
                        DW'(bus_cnt), DW'(it.exp_bus));
                    if (it.is_wr) begin
                        chk(cap_w == 1'b1, "R4 bus command is write", DW'(cap_w), 1);
                        chk(cap_a == it.addr, "R4 bus write address", DW'(cap_a), DW'(it.addr));
                        chk(cap_d == it.wdata, "R4 bus write data", cap_d, it.wdata);
                    end else begin
                        chk(cpu_rdata == it.exp_data, {it.tag, " read data"},
                            cpu_rdata, it.exp_data);
                        if (it.exp_bus != 0) begin
                            chk(cap_w == 1'b0, "R2 bus command is read", DW'(cap_w), 0);
                            chk(cap_a == it.addr, "R2 bus read address", DW'(cap_a),
                                DW'(it.addr));
                        end
                    end
                end
                bus_cnt = 0;
            end
            p_req = bus_req; p_gnt = bus_gnt; p_rdy = cpu_ready;
        end
    endtask

    task automatic stimulus();
        // R2 miss, R3 hit
        cpu_op(0, 16'h0010, '0, 1, "R2 first read misses");
        cpu_op(0, 16'h0010, '0, 0, "R3 read hit");
        // R4 write hit goes to bus, R6 update, R9 own echo ignored
        cpu_op(1, 16'h0010, 32'h1111_AAAA, 1, "R4 write hit");
        cpu_op(0, 16'h0010, '0, 0, "R6 read after write hit");
        cpu_op(0, 16'h0010, '0, 0, "R9 own write echo kept line");
        // R5 write miss, no allocate
        cpu_op(1, 16'h0021, 32'h2222_BBBB, 1, "R4 write miss");
        cpu_op(0, 16'h0021, '0, 1, "R5 read after write miss");
        cpu_op(0, 16'h0021, '0, 0, "R2 filled line hits");
        // R7 foreign write invalidates
        foreign(1, 16'h0010, 32'h3333_CCCC);
        cpu_op(0, 16'h0010, '0, 1, "R7 read after foreign write");
        // R8 other tag and foreign read keep the line
        foreign(1, 16'h0018, 32'h4444_DDDD);
        cpu_op(0, 16'h0010, '0, 0, "R8 other-tag foreign write");
        foreign(0, 16'h0010, '0);
        cpu_op(0, 16'h0010, '0, 0, "R8 foreign read");
        // R10 fill collides with a foreign write of the same address
        @(negedge clk);
        inj_race = 1'b1; inj_wr = 1'b1; inj_addr = 16'h0033; inj_data = 32'h5555_EEEE;
        inj_seq++;
        cpu_op(0, 16'h0033, '0, 1, "R10 read during collision");
        exp_mem[8'h33] = 32'h5555_EEEE;
        @(negedge clk);
        inj_race = 1'b0;
        cpu_op(0, 16'h0033, '0, 1, "R10 read after collision misses");
        cpu_op(0, 16'h0033, '0, 0, "R10 refetched line hits");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = init_word(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet outputs after reset
        chk(bus_req == 1'b0, "R1 bus_req after reset", DW'(bus_req), 0);
        chk(bus_cmd_valid == 1'b0, "R1 bus_cmd_valid after reset", DW'(bus_cmd_valid), 0);
        chk(cpu_ready == 1'b0, "R1 cpu_ready after reset", DW'(cpu_ready), 0);
        fork
            monitor();
            stimulus();
            begin
                repeat (20000) @(posedge clk);
                wd_fired = 1;
            end
        join_any
        disable fork;
        if (wd_fired) chk(1'b0, "watchdog expired", 1, 0);
        chk(viol_gnt == 0, "R11 command without grant", DW'(viol_gnt), 0);
        chk(viol_req == 0, "R11 request dropped before grant", DW'(viol_req), 0);
        chk(viol_ready == 0, "R12 ready longer than one cycle", DW'(viol_ready), 0);
        chk(n_ready == n_ops, "R12 completions per request", DW'(n_ready), DW'(n_ops));
        chk(sbq.size() == 0, "R12 outstanding expectations", DW'(sbq.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule